// File: doc/BRIEF.md
# Relocatable Peripheral Register Window Decoder

This block decides where a 4 KB window of internal peripheral registers sits in the external address map, and decodes each bus access against that placement. A single base register holds the window's starting address. Software reaches that register only through the CPU-control address space: the function code must be 4'h7 and the address must be 0x0003FF00. Normal memory accesses never reach it, whatever address they carry.

Each access is classified by its function code. A base-register access updates or returns the base. A data or program access whose upper address bits equal the stored base raises a window chip-select, and the low 12 address bits go out as the register offset. The window only moves in 4 KB steps. It stays closed until software sets an enable bit in the base register.

The chip-select, offset and read data are combinational from the current bus inputs. A base write takes effect at the next rising clock edge. Reset is synchronous and active high.

Top module: `regwin_decoder`

## Requirements
- R1: After reset the stored base is zero and the enable bit is clear. A base read then returns 0, and no address raises `win_sel`.
- R2: A write strobe with function code 4'h7 at address 0x0003FF00 loads `bus_wdata[31:12]` as the window base and `bus_wdata[0]` as the enable bit. The new value is in effect from the next rising clock edge.
- R3: A write to 0x0003FF00 with any function code other than 4'h7 leaves the base and the enable bit unchanged.
- R4: A read strobe with function code 4'h7 at address 0x0003FF00 returns, in the same cycle, the base in bits 31:12, the enable bit in bit 0, and zero in bits 11:1.
- R5: With the enable bit set, `win_sel` is high in the same cycle for any strobed access with function code 1, 2, 5 or 6 whose `bus_addr[31:12]` equals the stored base. This holds for both reads and writes.
- R6: While `win_sel` is high, `win_offset` equals `bus_addr[11:0]`. While `win_sel` is low, `win_offset` is zero.
- R7: While the enable bit is clear, no access raises `win_sel`, even when its upper address bits equal the stored base.
- R8: Function codes 0, 3, 4 and 7 never raise `win_sel`, even at an address inside the window.
- R9: Each of the following leaves `win_sel` low and `bus_rdata` at zero: an address outside the window in a non-CPU space, and any cycle without the strobe. A cycle without the strobe also never changes the base.
- R10: Bits 11:1 of a base write are discarded, and they read back as zero.
- R11: If the window is placed over 0x0003F000, a CPU-space access at 0x0003FF00 still goes to the base register and does not raise `win_sel`. A data access at the same address selects the window at offset 0xF00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Access strobe for the current cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_fc | input | 4 | Function code (address space) |
| bus_addr | input | 32 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (base register or zero) |
| win_sel | output | 1 | Chip-select for the relocated register window |
| win_offset | output | 12 | Register offset inside the window |

## Verification
Two functions can fall in the same cycle: a base-register access and a window decode of the same address. This happens once the window has been moved over the 4 KB page that holds 0x0003FF00. The bench provokes it by writing a base of 0x0003F000 with the enable bit set. It then presents 0x0003FF00 in CPU space and in data space, and checks that each access goes to exactly one target. The CPU-space access must return the base with `win_sel` low. The data-space access must give a window hit at offset 0xF00 with zero read data.

// File: rtl/regwin_pkg.sv
package regwin_pkg;
  typedef enum logic [1:0] {
    SPACE_OTHER = 2'd0,
    SPACE_CTRL  = 2'd1,
    SPACE_MEM   = 2'd2
  } space_e;
endpackage

// File: rtl/regwin_space_decode.sv
module regwin_space_decode
  import regwin_pkg::*;
#(
  parameter int                     FC_W        = 4,
  parameter logic [FC_W-1:0]        CTRL_FC     = 4'h7,
  parameter logic [(1<<FC_W)-1:0]   MEM_FC_MASK = 16'h0066
) (
  input  logic [FC_W-1:0] fc,
  output space_e          space
);
  localparam int FC_N = 1 << FC_W;

  logic [FC_N-1:0] is_mem;

  // One flag per function code, taken from the mask.
  // The control code is forced out of the memory set.
  for (genvar g = 0; g < FC_N; g++) begin : g_code
    assign is_mem[g] = MEM_FC_MASK[g] && (g != int'(CTRL_FC));
  end

  always_comb begin
    if (fc == CTRL_FC)  space = SPACE_CTRL;
    else if (is_mem[fc]) space = SPACE_MEM;
    else                space = SPACE_OTHER;
  end
endmodule

// File: rtl/regwin_base_reg.sv
module regwin_base_reg #(
  parameter int ADDR_W   = 32,
  parameter int WIN_BITS = 12
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_en,
  input  logic [ADDR_W-1:0]        wdata,
  output logic [ADDR_W-WIN_BITS-1:0] base_q,
  output logic                     base_en
);
  localparam int BASE_W = ADDR_W - WIN_BITS;

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q  <= '0;
      base_en <= 1'b0;
    end else if (wr_en) begin
      base_q  <= wdata[ADDR_W-1:WIN_BITS];
      base_en <= wdata[0];
    end
  end

  logic unused_low;
  assign unused_low = ^wdata[WIN_BITS-1:1] ^ (BASE_W == 0);
endmodule

// File: rtl/regwin_match.sv
module regwin_match #(
  parameter int ADDR_W   = 32,
  parameter int WIN_BITS = 12
) (
  input  logic                       strobe,
  input  logic                       mem_cycle,
  input  logic [ADDR_W-1:0]          addr,
  input  logic [ADDR_W-WIN_BITS-1:0] base_q,
  input  logic                       base_en,
  output logic                       hit,
  output logic [WIN_BITS-1:0]        offset
);
  logic page_eq;

  assign page_eq = (addr[ADDR_W-1:WIN_BITS] == base_q);
  assign hit     = strobe && mem_cycle && base_en && page_eq;
  assign offset  = hit ? addr[WIN_BITS-1:0] : '0;
endmodule

// File: rtl/regwin_decoder.sv
module regwin_decoder
  import regwin_pkg::*;
#(
  parameter int                    ADDR_W      = 32,
  parameter int                    FC_W        = 4,
  parameter int                    WIN_BITS    = 12,
  parameter logic [FC_W-1:0]       CTRL_FC     = 4'h7,
  parameter logic [(1<<FC_W)-1:0]  MEM_FC_MASK = 16'h0066,
  parameter logic [ADDR_W-1:0]     BASE_LOC    = 32'h0003_FF00
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bus_valid,
  input  logic                bus_write,
  input  logic [FC_W-1:0]     bus_fc,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [ADDR_W-1:0]   bus_wdata,
  output logic [ADDR_W-1:0]   bus_rdata,
  output logic                win_sel,
  output logic [WIN_BITS-1:0] win_offset
);
  localparam int BASE_W = ADDR_W - WIN_BITS;

  space_e              space;
  logic                ctrl_hit;
  logic                base_wr;
  logic                base_rd;
  logic [BASE_W-1:0]   base_q;
  logic                base_en;

  regwin_space_decode #(
    .FC_W(FC_W), .CTRL_FC(CTRL_FC), .MEM_FC_MASK(MEM_FC_MASK)
  ) u_space (
    .fc(bus_fc), .space(space)
  );

  assign ctrl_hit = bus_valid && (space == SPACE_CTRL) && (bus_addr == BASE_LOC);
  assign base_wr  = ctrl_hit && bus_write;
  assign base_rd  = ctrl_hit && !bus_write;

  regwin_base_reg #(
    .ADDR_W(ADDR_W), .WIN_BITS(WIN_BITS)
  ) u_base (
    .clk(clk), .rst(rst), .wr_en(base_wr), .wdata(bus_wdata),
    .base_q(base_q), .base_en(base_en)
  );

  regwin_match #(
    .ADDR_W(ADDR_W), .WIN_BITS(WIN_BITS)
  ) u_match (
    .strobe(bus_valid), .mem_cycle(space == SPACE_MEM), .addr(bus_addr),
    .base_q(base_q), .base_en(base_en), .hit(win_sel), .offset(win_offset)
  );

  always_comb begin
    if (base_rd) bus_rdata = {base_q, {(WIN_BITS-1){1'b0}}, base_en};
    else         bus_rdata = '0;
  end
endmodule

// File: rtl/regwin_decoder_chk.sv
module regwin_decoder_chk #(
  parameter int                ADDR_W   = 32,
  parameter int                FC_W     = 4,
  parameter int                WIN_BITS = 12,
  parameter logic [FC_W-1:0]   CTRL_FC  = 4'h7,
  parameter logic [ADDR_W-1:0] BASE_LOC = 32'h0003_FF00
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       bus_valid,
  input logic                       bus_write,
  input logic [FC_W-1:0]            bus_fc,
  input logic [ADDR_W-1:0]          bus_addr,
  input logic [ADDR_W-1:0]          bus_wdata,
  input logic [ADDR_W-1:0]          bus_rdata,
  input logic                       win_sel,
  input logic [WIN_BITS-1:0]        win_offset,
  input logic [ADDR_W-WIN_BITS-1:0] base_q,
  input logic                       base_en
);
  logic at_loc;
  assign at_loc = bus_valid && (bus_addr == BASE_LOC);

  // R1: first cycle after reset release sees a cleared base
  p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (base_q == '0 && !base_en));

  // R2: control-space write loads the base
  p_base_load_r2: assert property (@(posedge clk) disable iff (rst)
    (at_loc && bus_write && bus_fc == CTRL_FC) |=>
      (base_q == $past(bus_wdata[ADDR_W-1:WIN_BITS]) && base_en == $past(bus_wdata[0])));

  // R3: other function codes at the base address leave it alone
  p_other_fc_keep_r3: assert property (@(posedge clk) disable iff (rst)
    (at_loc && bus_write && bus_fc != CTRL_FC) |=> ($stable(base_q) && $stable(base_en)));

  // R5: a select always lies in the page named by the base
  p_sel_page_r5: assert property (@(posedge clk) disable iff (rst)
    win_sel |-> (bus_addr[ADDR_W-1:WIN_BITS] == base_q));

  // R7: no select while the window is disabled
  p_sel_enabled_r7: assert property (@(posedge clk) disable iff (rst)
    win_sel |-> base_en);

  // R8: control space never selects the window
  p_no_ctrl_sel_r8: assert property (@(posedge clk) disable iff (rst)
    win_sel |-> (bus_fc != CTRL_FC));

  // R9: no strobe, no select and no read data
  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    !bus_valid |-> (!win_sel && bus_rdata == '0));

  // R6: offset is zero whenever no select
  p_offset_zero_r6: assert property (@(posedge clk) disable iff (rst)
    !win_sel |-> (win_offset == '0));

  // R10: low unused read bits are zero
  p_rd_low_zero_r10: assert property (@(posedge clk) disable iff (rst)
    bus_rdata[WIN_BITS-1:1] == '0);
endmodule

bind regwin_decoder regwin_decoder_chk #(
  .ADDR_W(ADDR_W), .FC_W(FC_W), .WIN_BITS(WIN_BITS),
  .CTRL_FC(CTRL_FC), .BASE_LOC(BASE_LOC)
) u_chk (
  .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
  .bus_fc(bus_fc), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .bus_rdata(bus_rdata), .win_sel(win_sel), .win_offset(win_offset),
  .base_q(base_q), .base_en(base_en)
);

// File: tb/sim_regwin_decoder.sv
module sim_regwin_decoder;
  logic        clk = 1'b0;
  logic        rst;
  logic        bus_valid, bus_write;
  logic [3:0]  bus_fc;
  logic [31:0] bus_addr, bus_wdata, bus_rdata;
  logic        win_sel;
  logic [11:0] win_offset;

  int total = 0;
  int bad   = 0;

  always #5 clk = ~clk;

  regwin_decoder u0 (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_fc(bus_fc), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .win_sel(win_sel), .win_offset(win_offset)
  );

  localparam logic [31:0] LOC = 32'h0003_FF00;
  localparam int NV = 20;
  // {req, write, fc, addr, wdata, exp_sel, exp_off, exp_rdata}
  localparam logic [117:0] VEC [NV] = '{
    {4'd1,  1'b0, 4'h5, 32'h0000_0010, 32'h0,         1'b0, 12'h000, 32'h0},          // R1 no hit
    {4'd1,  1'b0, 4'h7, LOC,           32'h0,         1'b0, 12'h000, 32'h0},          // R1 base 0
    {4'd2,  1'b1, 4'h7, LOC,           32'h1234_5FFF, 1'b0, 12'h000, 32'h0},          // R2 write
    {4'd10, 1'b0, 4'h7, LOC,           32'h0,         1'b0, 12'h000, 32'h1234_5001},  // R10 R4 read
    {4'd5,  1'b0, 4'h5, 32'h1234_5ABC, 32'h0,         1'b1, 12'hABC, 32'h0},          // R5 fc5
    {4'd5,  1'b1, 4'h1, 32'h1234_5000, 32'hDEAD,      1'b1, 12'h000, 32'h0},          // R5 fc1 write
    {4'd6,  1'b0, 4'h2, 32'h1234_5FFF, 32'h0,         1'b1, 12'hFFF, 32'h0},          // R6 top offset
    {4'd5,  1'b0, 4'h6, 32'h1234_5800, 32'h0,         1'b1, 12'h800, 32'h0},          // R5 fc6
    {4'd9,  1'b0, 4'h6, 32'h1234_6000, 32'h0,         1'b0, 12'h000, 32'h0},          // R9 above
    {4'd9,  1'b0, 4'h5, 32'h1234_4FFF, 32'h0,         1'b0, 12'h000, 32'h0},          // R9 below
    {4'd8,  1'b0, 4'h7, 32'h1234_5100, 32'h0,         1'b0, 12'h000, 32'h0},          // R8 fc7
    {4'd8,  1'b0, 4'h0, 32'h1234_5100, 32'h0,         1'b0, 12'h000, 32'h0},          // R8 fc0
    {4'd8,  1'b0, 4'h3, 32'h1234_5100, 32'h0,         1'b0, 12'h000, 32'h0},          // R8 fc3
    {4'd8,  1'b1, 4'h4, 32'h1234_5100, 32'h0,         1'b0, 12'h000, 32'h0},          // R8 fc4
    {4'd3,  1'b1, 4'h5, LOC,           32'hFFFF_FFFE, 1'b0, 12'h000, 32'h0},          // R3 wrong fc
    {4'd3,  1'b0, 4'h7, LOC,           32'h0,         1'b0, 12'h000, 32'h1234_5001},  // R3 unchanged
    {4'd7,  1'b1, 4'h7, LOC,           32'h1234_5000, 1'b0, 12'h000, 32'h0},          // R7 disable
    {4'd7,  1'b0, 4'h5, 32'h1234_5010, 32'h0,         1'b0, 12'h000, 32'h0},          // R7 closed
    {4'd11, 1'b1, 4'h7, LOC,           32'h0003_F001, 1'b0, 12'h000, 32'h0},          // R11 overlap base
    {4'd11, 1'b0, 4'h5, LOC,           32'h0,         1'b1, 12'hF00, 32'h0}           // R11 data hit
  };

  task automatic check(input int req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL R%0d %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic w, input logic [3:0] fc,
                       input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_valid = v; bus_write = w; bus_fc = fc; bus_addr = a; bus_wdata = d;
    #2;
  endtask

  task automatic check_all(input int req, input logic s, input logic [11:0] o,
                           input logic [31:0] r);
    check(req, "win_sel", {31'b0, win_sel}, {31'b0, s});
    check(req, "win_offset", {20'b0, win_offset}, {20'b0, o});
    check(req, "bus_rdata", bus_rdata, r);
  endtask

  initial begin
    #200000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst = 1'b1; bus_valid = 0; bus_write = 0; bus_fc = 0; bus_addr = 0; bus_wdata = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      logic [117:0] v;
      v = VEC[i];
      drive(1'b1, v[113], v[112:109], v[108:77], v[76:45]);
      check_all(int'(v[117:114]), v[44], v[43:32], v[31:0]);
    end

    // R11: CPU-space read at base location inside window goes to base only
    drive(1'b1, 1'b0, 4'h7, LOC, 32'h0);
    check_all(11, 1'b0, 12'h000, 32'h0003_F001);

    // R9: no strobe -> no write, no select
    drive(1'b0, 1'b1, 4'h7, LOC, 32'hABCD_E001);
    check_all(9, 1'b0, 12'h000, 32'h0);
    drive(1'b0, 1'b0, 4'h5, LOC, 32'h0);
    check_all(9, 1'b0, 12'h000, 32'h0);
    drive(1'b1, 1'b0, 4'h7, LOC, 32'h0);
    check(9, "base after idle write", bus_rdata, 32'h0003_F001);

    // R1: reset in the middle of operation
    @(negedge clk); rst = 1'b1; bus_valid = 0;
    @(negedge clk); rst = 1'b0;
    drive(1'b1, 1'b0, 4'h7, LOC, 32'h0);
    check(1, "base after reset", bus_rdata, 32'h0);
    drive(1'b1, 1'b0, 4'h5, 32'h0000_0123, 32'h0);
    check(1, "no hit after reset", {31'b0, win_sel}, 32'h0);

    // R2: new base reachable the cycle after write
    drive(1'b1, 1'b1, 4'h7, LOC, 32'hFFFF_F001);
    check(2, "no hit during write", {31'b0, win_sel}, 32'h0);
    drive(1'b1, 1'b0, 4'h1, 32'hFFFF_F004, 32'h0);
    check(2, "hit at top page", {31'b0, win_sel}, 32'h1);
    check(6, "offset top page", {20'b0, win_offset}, 32'h004);

    @(negedge clk); bus_valid = 0;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule